// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Sequencer

This block sits between a synchronous host and an asynchronous extended-data-out DRAM of 4M words by 4 bits. The host hands over one read or one write at a time on a valid/ready handshake, with a 22-bit word address and 4 bits of write data. The sequencer then drives the row strobe, column strobe, write enable, output enable and the shared 11-bit address pins. It returns read data with a one-cycle valid strobe.

The upper 11 address bits select the row and the lower 11 bits select the column. After an access the row is left open. A later request to the same row is served as a page-mode column cycle and the row strobe does not toggle. A request to a different row first closes the row and waits out the full precharge. Every analogue limit is a nanosecond parameter that is rounded up to whole clock cycles for the chosen clock period. The maximum row-active time is the one exception: it is rounded down. Writes always use the early-write form, so the DRAM data pins are never driven by the memory during a write.

Top module: `edo_page_sequencer`

## Requirements
- R1: While reset is held and right after it, the row strobe, column strobe, write enable and output enable pins are all high (inactive). The data driver enable is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: A request address splits as row = `req_addr[21:11]` and column = `req_addr[10:0]`. The row is on `dram_addr` when the row strobe falls. The column is on `dram_addr` when the column strobe falls, and it stays stable while the column strobe is low.
- R3: The row strobe stays high for at least ceil(30 ns / clock) cycles between row activations. Once low, it stays low for at least ceil(50 ns / clock) cycles.
- R4: Read data is captured only after the column strobe has been low for at least max(ceil(14 ns), ceil(25 ns)) cycles and the row strobe has been low for at least ceil(50 ns) cycles. `rd_valid` is a single-cycle pulse carrying the word last written to that address, and reads return in request order.
- R5: A write is an early write. Write enable is driven low at least one full cycle before the column strobe falls, and output enable is high. The data driver is enabled with the write data before and during the column-strobe low time. Write enable is released when the column strobe rises.
- R6: During a read, write enable is high from at least one cycle before the column strobe falls until after it rises. Output enable is low and the data driver is disabled.
- R7: A request whose row equals the open row is served without a new row strobe fall. Between columns the column strobe stays high for at least ceil(10 ns) cycles, it stays low for at least ceil(8 ns) cycles, and falls of the column strobe are at least ceil(20 ns) cycles apart. The column strobe is low only while the row strobe is low.
- R8: A request to a different row closes the open row, precharges it and opens the new row, giving exactly one row strobe fall per row change.
- R9: The row strobe is never low for more than floor(10000 ns / clock) cycles, even when same-row requests arrive without a gap.
- R10: `req_ready` is 0 while the column strobe is low. A transfer takes place only on a clock edge where both `req_valid` and `req_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer can take the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in the upper 11 bits |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle strobe for read data |
| rd_data | output | 4 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 4 | Data towards the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 4 | Data from the DRAM |

## Verification
The behavioural DRAM in the bench returns the inverted word until both the column access time and the row access time have run out. A sequencer that samples even one cycle early therefore returns wrong data. Swapping or misaligning the row and column fields is caught by comparing each column access with the address the host requested, not only by reading the data back. A miss issued right after a row opens tests the minimum row-low time, and back-to-back rows test the precharge gap. A run of several hundred same-row writes must end with a forced row close: a design that ignores the row-active limit holds the row strobe low too long, and one with a wrong early-write setup moves write enable in the same cycle the column strobe falls.

// File: rtl/edo_seq_pkg.sv
// Shared types and helpers for the EDO page-mode sequencer.
// Assumes timing values are given as non-negative integers in nanoseconds.
package edo_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // row closed, precharge complete
        ST_RCD,    // row strobe low, row address held
        ST_CSET,   // column address and write enable settling
        ST_CLOW,   // column strobe low
        ST_CHIGH,  // column strobe high, row still open
        ST_PRE     // row strobe high, precharge running
    } seq_state_t;

    // Nanoseconds to clock cycles, rounded up.
    function automatic int ns_to_cyc_up(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_addr_mux.sv
// Splits a word address into row and column fields and picks the one
// the address pins should carry. Assumes the row sits in the upper bits.
// The narrower field is zero-extended to the pin width.
module edo_addr_mux #(
    parameter int ADDR_W = 22,
    parameter int ROW_W  = 11,
    localparam int COL_W = ADDR_W - ROW_W,
    localparam int PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_col,
    output logic [ROW_W-1:0]  row,
    output logic [PIN_W-1:0]  pin_addr
);
    logic [PIN_W-1:0] row_pin;
    logic [PIN_W-1:0] col_pin;

    assign row = addr[ADDR_W-1:COL_W];

    // Pad each field to the pin width when the two differ.
    generate
        if (ROW_W == PIN_W) begin : g_row_full
            assign row_pin = addr[ADDR_W-1:COL_W];
        end else begin : g_row_pad
            assign row_pin = {{(PIN_W-ROW_W){1'b0}}, addr[ADDR_W-1:COL_W]};
        end
        if (COL_W == PIN_W) begin : g_col_full
            assign col_pin = addr[COL_W-1:0];
        end else begin : g_col_pad
            assign col_pin = {{(PIN_W-COL_W){1'b0}}, addr[COL_W-1:0]};
        end
    endgenerate

    // Pick the phase of the multiplexed address.
    assign pin_addr = sel_col ? col_pin : row_pin;
endmodule

// File: rtl/edo_down_timer.sv
// Loadable down-counter for phase lengths. Holds at zero.
// Assumes load values fit in W bits.
module edo_down_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Count down toward zero, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/edo_row_window.sv
// Tracks how long the row strobe has been low. Says whether another
// column cycle still fits under the maximum row-active time and whether
// the minimum row-low time has passed. Assumes open_pulse marks the
// clock edge where the row strobe falls.
module edo_row_window #(
    parameter int MIN_LOW    = 5,
    parameter int MAX_LOW    = 1000,
    parameter int OPEN_LIMIT = 994,
    localparam int AGE_W     = $clog2(MAX_LOW + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic open_pulse,
    input  logic row_active,
    output logic may_extend,
    output logic may_close
);
    localparam logic [AGE_W-1:0] AGE_TOP   = AGE_W'(MAX_LOW);
    localparam logic [AGE_W-1:0] EXT_LIM   = AGE_W'(OPEN_LIMIT);
    localparam logic [AGE_W-1:0] CLOSE_MIN = AGE_W'(MIN_LOW - 1);

    logic [AGE_W-1:0] age;

    // Age of the open row in cycles, restarted on each activation.
    always_ff @(posedge clk) begin
        if (!rst_n)                            age <= '0;
        else if (open_pulse)                   age <= '0;
        else if (row_active && age != AGE_TOP) age <= age + 1'b1;
    end

    assign may_extend = (age <= EXT_LIM);
    assign may_close  = (age >= CLOSE_MIN);

    AST_ROW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        row_active |-> (age < AGE_TOP)); // R9
endmodule

// File: rtl/edo_page_sequencer.sv
// Sequencer for an asynchronous EDO DRAM: single reads and early writes
// from a valid/ready host, with the row left open for page-mode hits.
// Assumes the DRAM has been initialised and refreshed elsewhere, and that
// the row and column fields share one set of address pins.
module edo_page_sequencer #(
    parameter int ADDR_W        = 22,
    parameter int ROW_W         = 11,
    parameter int DQ_W          = 4,
    parameter int CLK_NS        = 10,
    parameter int T_RP_NS       = 30,
    parameter int T_RAS_MIN_NS  = 50,
    parameter int T_RAS_MAX_NS  = 10000,
    parameter int T_RCD_NS      = 14,
    parameter int T_CAS_NS      = 8,
    parameter int T_CP_NS       = 10,
    parameter int T_PC_NS       = 20,
    parameter int T_CAC_NS      = 14,
    parameter int T_AA_NS       = 25,
    parameter int T_RAC_NS      = 50,
    localparam int COL_W        = ADDR_W - ROW_W,
    localparam int PIN_W        = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   req_wdata,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [PIN_W-1:0]  dram_addr,
    output logic [DQ_W-1:0]   dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DQ_W-1:0]   dram_dq_in
);
    import edo_seq_pkg::*;

    localparam int C_RP       = imax(1, ns_to_cyc_up(T_RP_NS, CLK_NS));
    localparam int C_RAS_MIN  = imax(1, ns_to_cyc_up(T_RAS_MIN_NS, CLK_NS));
    localparam int C_RAS_MAX  = T_RAS_MAX_NS / CLK_NS;
    localparam int C_RCD      = imax(1, ns_to_cyc_up(T_RCD_NS, CLK_NS));
    localparam int C_CAS      = imax(1, ns_to_cyc_up(T_CAS_NS, CLK_NS));
    localparam int C_CP       = imax(1, ns_to_cyc_up(T_CP_NS, CLK_NS));
    localparam int C_PC       = ns_to_cyc_up(T_PC_NS, CLK_NS);
    localparam int C_RAC      = ns_to_cyc_up(T_RAC_NS, CLK_NS);
    localparam int C_ACC      = imax(C_CAS, imax(ns_to_cyc_up(T_CAC_NS, CLK_NS),
                                                 ns_to_cyc_up(T_AA_NS, CLK_NS)));
    localparam int C_RD_FIRST = imax(C_ACC, C_RAC - C_RCD - 1);
    localparam int C_WLOW     = imax(C_CAS, C_PC - C_CP);
    localparam int C_LOW_MAX  = imax(C_RD_FIRST, C_WLOW);
    localparam int C_OPEN_LIM = C_RAS_MAX - C_LOW_MAX - C_CP - 2;
    localparam int TW         = $clog2(imax(imax(C_RP, C_RCD), imax(C_LOW_MAX, C_CP)) + 1);

    seq_state_t          state;
    logic [ROW_W-1:0]    open_row;
    logic [ADDR_W-1:0]   cur_addr;
    logic                cur_wr;
    logic                cur_first;
    logic [DQ_W-1:0]     cur_wdata;
    logic [ROW_W-1:0]    req_row;
    logic [PIN_W-1:0]    req_row_pin;
    logic [ROW_W-1:0]    cur_row_unused;
    logic [PIN_W-1:0]    cur_col_pin;
    logic [PIN_W-1:0]    req_col_pin;
    logic [ROW_W-1:0]    req_row_dup;
    logic                tmr_load;
    logic [TW-1:0]       tmr_val;
    logic                tmr_zero;
    logic                win_extend;
    logic                win_close;
    logic                pre_done;
    logic                accept_new;
    logic                page_go;
    logic                close_now;
    logic                row_hit;
    int                  low_len;

    // Row phase and column phase of the incoming request.
    edo_addr_mux #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_req_row (
        .addr(req_addr), .sel_col(1'b0), .row(req_row), .pin_addr(req_row_pin));
    edo_addr_mux #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_req_col (
        .addr(req_addr), .sel_col(1'b1), .row(req_row_dup), .pin_addr(req_col_pin));
    // Column phase of the request held in flight.
    edo_addr_mux #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_cur_col (
        .addr(cur_addr), .sel_col(1'b1), .row(cur_row_unused), .pin_addr(cur_col_pin));

    edo_down_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero));

    edo_row_window #(.MIN_LOW(C_RAS_MIN), .MAX_LOW(C_RAS_MAX), .OPEN_LIMIT(C_OPEN_LIM)) u_window (
        .clk(clk), .rst_n(rst_n), .open_pulse(accept_new), .row_active(!dram_ras_n),
        .may_extend(win_extend), .may_close(win_close));

    // Handshake and row-hit decisions.
    always_comb begin
        row_hit    = (req_row == open_row);
        pre_done   = (state == ST_IDLE) || (state == ST_PRE && tmr_zero);
        page_go    = (state == ST_CHIGH) && tmr_zero && win_extend && req_valid && row_hit;
        close_now  = (state == ST_CHIGH) && tmr_zero && win_close &&
                     (!win_extend || (req_valid && !row_hit));
        req_ready  = pre_done || page_go;
        accept_new = pre_done && req_valid;
        low_len    = cur_wr ? C_WLOW : (cur_first ? C_RD_FIRST : C_ACC);
    end

    // Phase timer reloads at each state change that starts a timed phase.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (accept_new) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(C_RCD - 1);
        end else if (state == ST_CSET) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(low_len - 1);
        end else if (state == ST_CLOW && tmr_zero) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(C_CP - 1);
        end else if (close_now) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(C_RP - 1);
        end
    end

    // Main sequencer: state and registered DRAM pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            dram_ras_n  <= 1'b1;
            dram_cas_n  <= 1'b1;
            dram_we_n   <= 1'b1;
            dram_oe_n   <= 1'b1;
            dram_dq_oe  <= 1'b0;
            dram_dq_out <= '0;
            dram_addr   <= '0;
            rd_valid    <= 1'b0;
            rd_data     <= '0;
            open_row    <= '0;
            cur_addr    <= '0;
            cur_wr      <= 1'b0;
            cur_first   <= 1'b0;
            cur_wdata   <= '0;
        end else begin
            rd_valid <= 1'b0;
            unique case (state)
                ST_IDLE, ST_PRE: begin
                    if (accept_new) begin
                        dram_ras_n <= 1'b0;
                        dram_addr  <= req_row_pin;
                        open_row   <= req_row;
                        cur_addr   <= req_addr;
                        cur_wr     <= req_write;
                        cur_wdata  <= req_wdata;
                        cur_first  <= 1'b1;
                        state      <= ST_RCD;
                    end else if (pre_done) begin
                        state <= ST_IDLE;
                    end
                end
                ST_RCD: begin
                    if (tmr_zero) begin
                        dram_addr   <= cur_col_pin;
                        dram_we_n   <= !cur_wr;
                        dram_oe_n   <= cur_wr;
                        dram_dq_oe  <= cur_wr;
                        dram_dq_out <= cur_wdata;
                        state       <= ST_CSET;
                    end
                end
                ST_CSET: begin
                    dram_cas_n <= 1'b0;
                    state      <= ST_CLOW;
                end
                ST_CLOW: begin
                    if (tmr_zero) begin
                        dram_cas_n <= 1'b1;
                        dram_we_n  <= 1'b1;
                        dram_oe_n  <= 1'b1;
                        dram_dq_oe <= 1'b0;
                        cur_first  <= 1'b0;
                        if (!cur_wr) begin
                            rd_valid <= 1'b1;
                            rd_data  <= dram_dq_in;
                        end
                        state <= ST_CHIGH;
                    end
                end
                ST_CHIGH: begin
                    if (page_go) begin
                        cur_addr    <= req_addr;
                        cur_wr      <= req_write;
                        cur_wdata   <= req_wdata;
                        dram_addr   <= req_col_pin;
                        dram_we_n   <= !req_write;
                        dram_oe_n   <= req_write;
                        dram_dq_oe  <= req_write;
                        dram_dq_out <= req_wdata;
                        state       <= ST_CSET;
                    end else if (close_now) begin
                        dram_ras_n <= 1'b1;
                        state      <= ST_PRE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n); // R7
    AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> $stable(dram_we_n)); // R5
    AST_WE_HIGH_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && !dram_oe_n) |-> dram_we_n); // R6
    AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> (dram_oe_n && !dram_we_n)); // R5
    AST_COL_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr)); // R2
    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R4
    AST_RAS_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> $past(win_close)); // R3
    AST_NO_READY_CAS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !req_ready); // R10
endmodule

// File: tb/tb_edo_page_sequencer.sv
// Scoreboard bench: a driver task queues the expected pin accesses and
// read data, a behavioural DRAM checks the pin timing, and a monitor
// compares the returned reads.
module tb_edo_page_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int C_RP      = (30 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int C_RASMIN  = (50 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int C_RASMAX  = 10000 / CLK_PERIOD;
    localparam int C_CASW    = (8 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int C_CP      = (10 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int C_PC      = (20 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int C_CAC     = (14 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int C_AA      = (25 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int C_ACC     = (C_CAC > C_AA) ? C_CAC : C_AA;
    localparam int C_RAC     = (50 + CLK_PERIOD - 1) / CLK_PERIOD;

    typedef struct {
        logic        wr;
        logic [21:0] addr;
        logic [3:0]  data;
    } acc_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [21:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        rd_valid;
    logic [3:0]  rd_data;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [10:0] dram_addr;
    logic [3:0]  dram_dq_out;
    logic [3:0]  dram_dq_in = '0;

    int checks = 0;
    int fails  = 0;
    acc_t       acc_q[$];
    logic [3:0] rd_q[$];
    logic [3:0] shadow [int];
    logic [3:0] mem [int];

    edo_page_sequencer dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: queue expectations, then run one handshake.
    task automatic do_req(input bit wr, input logic [21:0] a, input logic [3:0] d);
        acc_t e;
        e.wr = wr; e.addr = a; e.data = d;
        acc_q.push_back(e);
        if (wr) shadow[int'(a)] = d;
        else    rd_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        #1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (acc_q.size() != 0 || rd_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Behavioural DRAM responder with pin timing checks.
    bit         prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1, first_col = 1'b1, cur_rd = 1'b0;
    int         ras_hi = 1000, ras_lo = 0, cas_hi = 1000, cas_lo = 0, fall_gap = 1000;
    int         ras_falls = 0;
    logic [10:0] cur_row = '0;
    logic [3:0]  rd_word = '0;
    bit          prev_rdv = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras && !dram_ras_n) begin
                check(ras_hi >= C_RP, "R3", "precharge cycles", ras_hi, C_RP);
                cur_row = dram_addr; ras_lo = 1; ras_falls++; first_col = 1'b1;
            end else if (!prev_ras && dram_ras_n) begin
                check(ras_lo >= C_RASMIN, "R3", "row low cycles", ras_lo, C_RASMIN);
                check(ras_lo <= C_RASMAX, "R9", "row low cycles", ras_lo, C_RASMAX);
                ras_hi = 1;
            end else if (!dram_ras_n) ras_lo++;
            else ras_hi++;

            if (prev_cas && !dram_cas_n) begin
                acc_t e;
                check(!dram_ras_n, "R7", "row strobe at column fall", dram_ras_n, 0);
                if (!first_col) begin
                    check(cas_hi >= C_CP, "R7", "column precharge", cas_hi, C_CP);
                    check(fall_gap >= C_PC, "R7", "page cycle", fall_gap, C_PC);
                end
                check(dram_we_n == prev_we, "R5", "write enable setup", dram_we_n, prev_we);
                if (acc_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected column access", 1, 0);
                end else begin
                    e = acc_q.pop_front();
                    check({cur_row, dram_addr} == e.addr, "R2", "row/column address",
                          {cur_row, dram_addr}, e.addr);
                    check(dram_we_n == !e.wr, "R5", "write enable level", dram_we_n, !e.wr);
                end
                if (!dram_we_n) begin
                    check(dram_dq_oe && dram_oe_n, "R5", "driver on and output off",
                          {dram_dq_oe, dram_oe_n}, 3);
                    check(dram_dq_out == e.data, "R5", "write data", dram_dq_out, e.data);
                    mem[int'({cur_row, dram_addr})] = dram_dq_out;
                end else begin
                    check(!dram_dq_oe && !dram_oe_n, "R6", "read enables",
                          {dram_dq_oe, dram_oe_n}, 0);
                    rd_word = mem.exists(int'({cur_row, dram_addr})) ?
                              mem[int'({cur_row, dram_addr})] : 4'h0;
                end
                cur_rd = dram_we_n; cas_lo = 1; fall_gap = 0; first_col = 1'b0;
            end else if (!prev_cas && dram_cas_n) begin
                check(cas_lo >= C_CASW, "R7", "column low cycles", cas_lo, C_CASW);
                if (cur_rd) check(dram_we_n, "R6", "write enable after read", dram_we_n, 1);
                cas_hi = 1;
            end else if (!dram_cas_n) begin
                cas_lo++;
                if (cur_rd) check(dram_we_n, "R6", "write enable during read", dram_we_n, 1);
            end else cas_hi++;
            fall_gap++;

            if (!dram_cas_n)
                check(!req_ready, "R10", "ready while column low", req_ready, 0);
            if (!dram_cas_n && cur_rd)
                dram_dq_in = (cas_lo >= C_ACC && ras_lo >= C_RAC) ? rd_word : ~rd_word;

            prev_ras = dram_ras_n; prev_cas = dram_cas_n; prev_we = dram_we_n;
        end
    end

    // Monitor: compare returned reads with the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                check(!prev_rdv, "R4", "valid pulse width", 2, 1);
                if (rd_q.size() == 0) check(1'b0, "R4", "unexpected read", 1, 0);
                else begin
                    logic [3:0] x;
                    x = rd_q.pop_front();
                    check(rd_data == x, "R4", "read data", rd_data, x);
                end
            end
            prev_rdv = rd_valid;
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1", "strobes idle",
              {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
        check(!dram_dq_oe && !rd_valid, "R1", "driver and valid", {dram_dq_oe, rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready, "R1", "ready after reset", req_ready, 1);
        check(dram_ras_n, "R1", "row strobe after reset", dram_ras_n, 1);

        // R7: page hits in one row
        base = ras_falls;
        for (int i = 0; i < 6; i++) do_req(1'b1, {11'h155, 11'(i * 37)}, 4'(i + 3));
        for (int i = 0; i < 6; i++) do_req(1'b0, {11'h155, 11'(i * 37)}, 4'h0);
        drain();
        check(ras_falls - base == 1, "R7", "row opens for page burst", ras_falls - base, 1);

        // R8: alternating rows, miss issued right after an open
        base = ras_falls;
        for (int i = 0; i < 4; i++) do_req(1'b1, {11'(i + 1), 11'h2AA}, 4'(9 - i));
        for (int i = 0; i < 4; i++) do_req(1'b0, {11'(i + 1), 11'h2AA}, 4'h0);
        drain();
        check(ras_falls - base == 8, "R8", "row opens for misses", ras_falls - base, 8);

        // R2: extreme addresses
        do_req(1'b1, 22'h000000, 4'hA);
        do_req(1'b1, 22'h3FFFFF, 4'h5);
        do_req(1'b0, 22'h000000, 4'h0);
        do_req(1'b0, 22'h3FFFFF, 4'h0);
        do_req(1'b1, 22'h3FF800, 4'hC);
        do_req(1'b0, 22'h3FF800, 4'h0);
        drain();

        // R9: continuous same-row writes must force a row close
        base = ras_falls;
        for (int i = 0; i < 420; i++) do_req(1'b1, {11'h0F0, 11'(i)}, 4'(i ^ 5));
        drain();
        check(ras_falls - base >= 2, "R9", "forced row close", ras_falls - base, 2);
        for (int i = 0; i < 420; i += 97) do_req(1'b0, {11'h0F0, 11'(i)}, 4'h0);
        drain();

        // R4: read of a row left open while idle, then let the window expire
        do_req(1'b0, {11'h155, 11'd74}, 4'h0);
        repeat (1100) @(negedge clk);
        check(dram_ras_n, "R9", "idle row closed by window", dram_ras_n, 1);
        do_req(1'b0, {11'h155, 11'd74}, 4'h0);
        drain();
        finish_run();
    end
endmodule